// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit performs one 32-bit multiplication or division at a time and keeps the outcome in a dedicated pair of result registers, HI and LO, that are kept apart from the general register file. A pulse on the start input captures the operation code and both operands. The unit then runs an iterative datapath that handles one operand bit per cycle. It is a shift-and-add engine for products and a restoring engine for quotients. When the run ends, the two result registers are written together. The results stay readable on two output ports, which serve the instructions that copy HI or LO into a general register.

The busy flag is the only link to the pipeline. Issue logic stalls any later multiply, divide or result read while busy is high. Signed operands are reduced to magnitudes at capture time. The signs are applied again in the cycle that writes the result. A zero divisor does not trap. It produces a fixed and documented result.

Top module: `muldiv_hilo`

## Requirements
- R1: While reset is asserted, and right after it is released, busy_o is 0 and hi_o and lo_o are both 0.
- R2: The 2-bit op_i code selects 00 signed multiply, 01 unsigned multiply, 10 signed divide, 11 unsigned divide. A start_i sampled high while busy_o is low begins an operation. busy_o is high for exactly 33 clock cycles starting with the next cycle. hi_o and lo_o take the new result on the same edge that lowers busy_o.
- R3: A signed multiply places the upper half of the 64-bit two's-complement product on hi_o and the lower half on lo_o.
- R4: An unsigned multiply places the 64-bit unsigned product on hi_o:lo_o.
- R5: A signed divide with a nonzero divisor puts the quotient, truncated toward zero, on lo_o. It puts the remainder, which carries the dividend's sign, on hi_o.
- R6: An unsigned divide with a nonzero divisor puts the unsigned quotient on lo_o and the unsigned remainder on hi_o.
- R7: Division by zero finishes in the normal 33 cycles, and hi_o equals the dividend. lo_o is all ones for an unsigned divide, and also for a signed divide with a non-negative dividend. lo_o is 1 for a signed divide with a negative dividend.
- R8: Operands and op code are captured only at the accepted start. A start_i pulse while busy_o is high is ignored, and that includes the last busy cycle. It neither extends busy_o nor changes the result, and busy_o stays low afterwards.
- R9: hi_o and lo_o change only on the edge that completes an operation. Otherwise they hold their values.
- R10: The signed divide of 0x80000000 by 0xFFFFFFFF yields lo_o = 0x80000000 and hi_o = 0.

Top module ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation when the unit is idle |
| op_i | input | 2 | Operation code (see R2) |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| hi_o | output | 32 | HI register: upper product half or remainder |
| lo_o | output | 32 | LO register: lower product half or quotient |

## Verification
Two events can share one clock edge: a new start request and the completion of the running operation. On the edge that writes HI and LO and lowers busy, a start sampled in that cycle must be dropped. The bench raises start exactly in the 33rd busy cycle, and in a middle cycle on another run. In both cases it checks that the busy run is still 33 cycles long and that the result belongs to the first operands. It also checks that busy stays low on the following cycle. In every run the operand and op inputs are scrambled right after the accepted start, which shows they are only sampled at acceptance.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;
endpackage

// File: rtl/muldiv_prep.sv
// Operand conditioning: magnitudes for signed ops plus result sign flags.
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         is_div_o,
  output logic         neg_res_o,
  output logic         neg_rem_o
);
  md_op_e op;
  logic   sgn;

  always_comb begin
    op        = md_op_e'(op_i);
    sgn       = (op == OP_MUL_S) || (op == OP_DIV_S);
    is_div_o  = (op == OP_DIV_S) || (op == OP_DIV_U);
    mag_a_o   = (sgn && opa_i[W-1]) ? (~opa_i + W'(1)) : opa_i;
    mag_b_o   = (sgn && opb_i[W-1]) ? (~opb_i + W'(1)) : opb_i;
    neg_res_o = sgn && (opa_i[W-1] ^ opb_i[W-1]);
    neg_rem_o = sgn && is_div_o && opa_i[W-1];
  end
endmodule

// File: rtl/muldiv_step.sv
// One iteration: shift-add multiply or restoring divide, one bit per call.
module muldiv_step #(
  parameter int W = 32
) (
  input  logic           is_div_i,
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   opnd_i,
  output logic [2*W-1:0] acc_o
);
  localparam int AW = 2 * W;

  logic [W:0]   sum;
  logic [W:0]   rem_sh;
  logic [W+1:0] diff;
  logic         fits;

  always_comb begin
    // multiply: conditionally add the multiplicand to the upper half, shift right
    sum    = {1'b0, acc_i[AW-1:W]} + (acc_i[0] ? {1'b0, opnd_i} : '0);
    // divide: shift remainder/quotient left, trial-subtract the divisor
    rem_sh = acc_i[AW-1:W-1];
    diff   = {1'b0, rem_sh} - {2'b00, opnd_i};
    fits   = ~diff[W+1];
    if (is_div_i) begin
      acc_o = {(fits ? diff[W-1:0] : rem_sh[W-1:0]), acc_i[W-2:0], fits};
    end else begin
      acc_o = {sum, acc_i[W-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction and HI/LO split.
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic           is_div_i,
  input  logic           neg_res_i,
  input  logic           neg_rem_i,
  input  logic [2*W-1:0] acc_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o
);
  localparam int AW = 2 * W;

  logic [AW-1:0] prod;
  logic [W-1:0]  quo;
  logic [W-1:0]  rem;

  always_comb begin
    prod = neg_res_i ? (~acc_i + AW'(1)) : acc_i;
    quo  = neg_res_i ? (~acc_i[W-1:0] + W'(1)) : acc_i[W-1:0];
    rem  = neg_rem_i ? (~acc_i[AW-1:W] + W'(1)) : acc_i[AW-1:W];
    if (is_div_i) begin
      hi_o = rem;
      lo_o = quo;
    end else begin
      hi_o = prod[AW-1:W];
      lo_o = prod[W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);
  localparam int AW = 2 * W;

  // control state
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  hi_q, lo_q;
  // datapath state
  logic [AW-1:0] acc_q, acc_d;
  logic [W-1:0]  opnd_q;
  logic          isdiv_q, negres_q, negrem_q;

  // combinational nets
  logic [W-1:0]  mag_a, mag_b;
  logic          is_div, neg_res, neg_rem;
  logic [AW-1:0] acc_step;
  logic [W-1:0]  hi_fin, lo_fin;
  logic          load_en, step_en, done_en;

  muldiv_prep #(.W(W)) u_prep (
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .is_div_o (is_div),
    .neg_res_o(neg_res),
    .neg_rem_o(neg_rem)
  );

  muldiv_step #(.W(W)) u_step (
    .is_div_i(isdiv_q),
    .acc_i   (acc_q),
    .opnd_i  (opnd_q),
    .acc_o   (acc_step)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div_i (isdiv_q),
    .neg_res_i(negres_q),
    .neg_rem_i(negrem_q),
    .acc_i    (acc_q),
    .hi_o     (hi_fin),
    .lo_o     (lo_fin)
  );

  // next-state logic
  always_comb begin
    load_en = start_i && !busy_q;
    step_en = busy_q && (cnt_q != CW'(W));
    done_en = busy_q && (cnt_q == CW'(W));

    busy_d = busy_q;
    if (load_en)      busy_d = 1'b1;
    else if (done_en) busy_d = 1'b0;

    cnt_d = cnt_q;
    if (load_en)      cnt_d = '0;
    else if (step_en) cnt_d = cnt_q + CW'(1);

    acc_d = load_en ? {{W{1'b0}}, mag_a} : acc_step;
  end

  // control and architectural registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (done_en) begin
        hi_q <= hi_fin;
        lo_q <= lo_fin;
      end
    end
  end

  // datapath registers, enable-only
  always_ff @(posedge clk) begin
    if (load_en) begin
      opnd_q   <= mag_b;
      isdiv_q  <= is_div;
      negres_q <= neg_res;
      negrem_q <= neg_rem;
    end
    if (load_en || step_en) begin
      acc_q <= acc_d;
    end
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W   = 32,
  parameter int RUN = 33
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int LW = $clog2(RUN + 1) + 1;

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (busy_o) len_q <= len_q + LW'(1);
    else             len_q <= '0;
  end

  // R2: an accepted start raises busy on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R2: without a start the idle unit stays idle
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !busy_o) |=> !busy_o);

  // R2: each busy run is exactly RUN cycles long
  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> (len_q == LW'(RUN)));

  // R8: a start during busy never stretches the run
  a_r8_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (len_q < LW'(RUN)));

  // R9: results move only on the completing edge
  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hi_o) || !$stable(lo_o)) |-> $fell(busy_o));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W), .RUN(W + 1)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy_o (busy_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYC    = 33;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;

  muldiv_hilo #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [63:0] r;
    longint sa, sb, q, m;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: r = 64'(sa * sb);
      2'b01: r = {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) r = {a, (a[31] ? 32'h1 : 32'hFFFF_FFFF)};
        else begin
          q = sa / sb;
          m = sa % sb;
          r = {m[31:0], q[31:0]};
        end
      end
      default: begin
        if (b == 0) r = {a, 32'hFFFF_FFFF};
        else        r = {a % b, a / b};
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] op, input logic [31:0] b);
    if (op[1] && b == 0) return "R7";
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation starting at a negedge; inj>0 raises start_i in that busy cycle.
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input int inj, input string tag);
    logic [63:0] exp;
    int nbusy;
    exp = model(op, a, b);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0; op_i = 2'($urandom); opa_i = $urandom; opb_i = $urandom;  // R8 scramble
    nbusy = 0;
    for (int k = 1; k <= RUN_CYC + 8; k++) begin
      if (!busy_o) break;
      nbusy++;
      start_i = (k == inj);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R2 busy length", 64'(nbusy), 64'(RUN_CYC));
    chk(tag, {hi_o, lo_o}, exp);
    if (inj > 0) begin
      @(negedge clk);
      chk("R8 stays idle after ignored start", {63'b0, busy_o}, 64'b0);
      chk("R8 result unchanged", {hi_o, lo_o}, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset state in reset", {31'b0, busy_o, hi_o}, 64'b0);
    chk("R1 lo in reset", {32'b0, lo_o}, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state after release", {31'b0, busy_o, lo_o}, 64'b0);

    // directed corners
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R3");
    run_op(2'b00, 32'h0000_0007, 32'hFFFF_FFFD, 0, "R3");
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4");
    run_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002, 0, "R5");
    run_op(2'b10, 32'h0000_0007, 32'hFFFF_FFFE, 33, "R5 with start in last busy cycle R8");
    run_op(2'b11, 32'hFFFF_FFFF, 32'h0000_0001, 5, "R6 with start mid-run R8");
    run_op(2'b11, 32'h1234_5678, 32'h0, 0, "R7");
    run_op(2'b10, 32'h1234_5678, 32'h0, 0, "R7");
    run_op(2'b10, 32'hFEDC_BA98, 32'h0, 0, "R7");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R10");

    // R9: results hold while idle with operand inputs toggling
    for (int i = 0; i < 6; i++) begin
      opa_i = $urandom; opb_i = $urandom; op_i = 2'($urandom);
      @(negedge clk);
    end
    chk("R9 hold while idle", {hi_o, lo_o}, model(2'b10, 32'h8000_0000, 32'hFFFF_FFFF));

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      op = 2'($urandom);
      a  = $urandom;
      case ($urandom % 4)
        0:       b = $urandom % 16;
        1:       b = $urandom % 65536;
        2:       b = -($urandom % 8);
        default: b = $urandom;
      endcase
      run_op(op, a, b, ($urandom % 5 == 0) ? int'(1 + $urandom % RUN_CYC) : 0, tag_of(op, b));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule